// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block decides which of the SIMD lanes of a thread group are enabled while the group runs through nested conditional code. Each branch event carries one predicate bit per lane. If every enabled lane agrees, the block only steers the program counter. If the enabled lanes disagree, the branch is divergent. The block then narrows the enabled set to the lanes that took the branch and records one stack entry. That entry keeps everything needed to run the other side later and to rejoin afterwards.

A convergence marker acts as a barrier. The first marker after a divergence switches the group to the lanes that did not take the branch. The second marker restores the mask that was in force before the branch, jumps to the join address and releases the entry. Because entries stack, inner branches can diverge inside an outer path and unwind in last-in, first-out order. The two sides of an if-else therefore run one after the other with disjoint masks, so each side occupies only part of the lanes.

Instruction fetch and the lanes themselves sit outside this block. Fetch presents branch and marker events and follows `next_pc`. The lanes obey `act_mask`.

Top module: `simt_divergence_ctl`

## Requirements
- R1: After a synchronous active-low reset, `act_mask` is all ones, `next_pc` equals the parameter `RESET_PC`, `ovf` is 0 and the stack is empty.
- R2: A branch where every enabled lane has predicate 1 sets `next_pc` to `br_target` on the next clock. It leaves `act_mask` unchanged and pushes nothing.
- R3: A branch where every enabled lane has predicate 0 sets `next_pc` to `br_fall` on the next clock. It leaves `act_mask` unchanged and pushes nothing.
- R4: A divergent branch (some enabled lanes 1, others 0) with a non-full stack pushes one entry. On the next clock it sets `act_mask` to enabled AND predicate and `next_pc` to `br_target`.
- R5: The first convergence marker after a divergence sets `act_mask` to enabled AND NOT predicate of that branch and `next_pc` to its `br_fall`, without popping.
- R6: The second convergence marker for that entry pops it, restores the pre-branch `act_mask`, and sets `next_pc` to that branch's `br_join_pc`.
- R7: A branch inside a path is judged against the current `act_mask`. Nested entries unwind innermost first.
- R8: A convergence marker with an empty stack changes neither `act_mask` nor `next_pc`.
- R9: A divergent branch while the stack holds `DEPTH` entries sets `ovf`, which stays 1 until reset. The branch changes neither `act_mask` nor `next_pc`, and nothing is pushed.
- R10: When a branch and a convergence marker arrive in the same cycle, the marker takes effect and the branch is ignored.
- R11: Predicate bits of disabled lanes have no effect. A branch on which all enabled lanes agree is treated as uniform whatever the other bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| br_valid | input | 1 | Branch event this cycle |
| br_pred | input | LANES | Per-lane branch outcome, 1 = taken |
| br_target | input | PCW | Taken-path address |
| br_fall | input | PCW | Not-taken-path address |
| br_join_pc | input | PCW | Address where both paths rejoin |
| merge_valid | input | 1 | Convergence marker event this cycle |
| act_mask | output | LANES | Lanes enabled for the current path |
| next_pc | output | PCW | Address fetch is to continue from |
| ovf | output | 1 | Sticky flag: a push was refused on a full stack |

## Verification
The functions that can share a cycle are the branch handler and the convergence handler. Fetch may present `br_valid` and `merge_valid` together, and a full stack can also meet a divergent branch. The bench drives both events on one clock in two situations. In the first, an entry is pending and the branch would itself have redirected. The bench then checks that mask and address follow the marker alone, and that a second marker unwinds exactly one level. In the second, the stack is empty, and nothing may change. Overflow is reached by filling a reduced-depth stack. The bench then checks that the refused branch leaves mask and address untouched, and that unwinding needs exactly twice the depth in markers.

// File: rtl/simt_div_pkg.sv
// Package: shared decode for the divergence controller.
// Assumes: one event is acted on per clock; OP values are internal only.
package simt_div_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,  // nothing to do
        OP_TAKE  = 3'd1,  // uniform branch, all enabled lanes taken
        OP_SKIP  = 3'd2,  // uniform branch, no enabled lane taken
        OP_SPLIT = 3'd3,  // divergent branch, entry pushed
        OP_SPILL = 3'd4,  // divergent branch on a full stack
        OP_FLIP  = 3'd5,  // first marker: switch to the waiting path
        OP_POP   = 3'd6   // second marker: rejoin and release entry
    } div_op_e;

endpackage

// File: rtl/simt_lane_split.sv
// Module: simt_lane_split
// Splits the enabled lanes by predicate and classifies the branch.
// Assumes: combinational only; predicate bits of disabled lanes are don't-care.
module simt_lane_split #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] act,
    input  logic [LANES-1:0] pred,
    output logic [LANES-1:0] take_mask,
    output logic [LANES-1:0] skip_mask,
    output logic             all_take,
    output logic             none_take,
    output logic             split
);

    // Per-lane partition of the enabled set.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign take_mask[l] = act[l] & pred[l];
        assign skip_mask[l] = act[l] & ~pred[l];
    end

    // Branch class: uniform taken wins when no lane is enabled.
    always_comb begin
        all_take  = (take_mask == act);
        none_take = (take_mask == '0) && !all_take;
        split     = !all_take && !none_take;
    end

endmodule

// File: rtl/simt_mask_stack.sv
// Module: simt_mask_stack
// LIFO of divergence entries: restore mask, waiting mask and address,
// join address and a flag telling whether the waiting path has started.
// Assumes: caller never pushes when full nor flips/pops when empty;
// push, flip and pop are mutually exclusive.
module simt_mask_stack #(
    parameter int LANES = 8,
    parameter int DEPTH = 8,
    parameter int PCW   = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LANES-1:0] push_restore,
    input  logic [LANES-1:0] push_alt,
    input  logic [PCW-1:0]   push_alt_pc,
    input  logic [PCW-1:0]   push_join_pc,
    input  logic             flip,
    input  logic             pop,
    output logic [LANES-1:0] top_restore,
    output logic [LANES-1:0] top_alt,
    output logic [PCW-1:0]   top_alt_pc,
    output logic [PCW-1:0]   top_join_pc,
    output logic             top_flipped,
    output logic [CW-1:0]    depth
);

    logic [LANES-1:0] restore_q [DEPTH];
    logic [LANES-1:0] alt_q     [DEPTH];
    logic [PCW-1:0]   altpc_q   [DEPTH];
    logic [PCW-1:0]   joinpc_q  [DEPTH];
    logic [DEPTH-1:0] flipped_q;
    logic [CW-1:0]    cnt_q;
    logic [IW-1:0]    top_idx;

    // Index of the newest entry (wraps when empty; outputs unused then).
    assign top_idx = IW'(cnt_q - CW'(1));

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (push) cnt_q <= cnt_q + CW'(1);
        else if (pop)  cnt_q <= cnt_q - CW'(1);
    end

    // Entry storage, one slot per level.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture on push into this slot; mark waiting path started on flip.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                restore_q[g]  <= '0;
                alt_q[g]      <= '0;
                altpc_q[g]    <= '0;
                joinpc_q[g]   <= '0;
                flipped_q[g]  <= 1'b0;
            end else if (push && cnt_q == CW'(g)) begin
                restore_q[g]  <= push_restore;
                alt_q[g]      <= push_alt;
                altpc_q[g]    <= push_alt_pc;
                joinpc_q[g]   <= push_join_pc;
                flipped_q[g]  <= 1'b0;
            end else if (flip && top_idx == IW'(g)) begin
                flipped_q[g]  <= 1'b1;
            end
        end
    end

    // Top-of-stack view.
    always_comb begin
        top_restore = restore_q[top_idx];
        top_alt     = alt_q[top_idx];
        top_alt_pc  = altpc_q[top_idx];
        top_join_pc = joinpc_q[top_idx];
        top_flipped = flipped_q[top_idx];
        depth       = cnt_q;
    end

endmodule

// File: rtl/simt_divergence_ctl.sv
// Module: simt_divergence_ctl (top)
// Tracks the enabled-lane mask and the fetch address through nested
// divergent branches, using one stack entry per divergence.
// Assumes: at most one branch and one marker per clock; a marker in the
// same cycle as a branch wins and the branch is dropped.
module simt_divergence_ctl
    import simt_div_pkg::*;
#(
    parameter int             LANES    = 8,
    parameter int             DEPTH    = 8,
    parameter int             PCW      = 16,
    parameter logic [PCW-1:0] RESET_PC = '0,
    localparam int            CW       = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_pred,
    input  logic [PCW-1:0]   br_target,
    input  logic [PCW-1:0]   br_fall,
    input  logic [PCW-1:0]   br_join_pc,
    input  logic             merge_valid,
    output logic [LANES-1:0] act_mask,
    output logic [PCW-1:0]   next_pc,
    output logic             ovf
);

    logic [LANES-1:0] mask_q;
    logic [PCW-1:0]   pc_q;
    logic             ovf_q;

    logic [LANES-1:0] take_mask, skip_mask;
    logic             all_take, none_take, split;

    logic [LANES-1:0] top_restore, top_alt;
    logic [PCW-1:0]   top_alt_pc, top_join_pc;
    logic             top_flipped;
    logic [CW-1:0]    depth;
    logic             stk_empty, stk_full;
    div_op_e          op;

    simt_lane_split #(.LANES(LANES)) u_split (
        .act       (mask_q),
        .pred      (br_pred),
        .take_mask (take_mask),
        .skip_mask (skip_mask),
        .all_take  (all_take),
        .none_take (none_take),
        .split     (split)
    );

    simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH), .PCW(PCW)) u_stack (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (op == OP_SPLIT),
        .push_restore (mask_q),
        .push_alt     (skip_mask),
        .push_alt_pc  (br_fall),
        .push_join_pc (br_join_pc),
        .flip         (op == OP_FLIP),
        .pop          (op == OP_POP),
        .top_restore  (top_restore),
        .top_alt      (top_alt),
        .top_alt_pc   (top_alt_pc),
        .top_join_pc  (top_join_pc),
        .top_flipped  (top_flipped),
        .depth        (depth)
    );

    // Stack occupancy flags.
    assign stk_empty = (depth == '0);
    assign stk_full  = (depth == CW'(DEPTH));

    // Event decode: marker first, then branch class.
    always_comb begin
        op = OP_IDLE;
        if (merge_valid) begin
            if (!stk_empty) op = top_flipped ? OP_POP : OP_FLIP;
        end else if (br_valid) begin
            if (split)          op = stk_full ? OP_SPILL : OP_SPLIT;
            else if (all_take)  op = OP_TAKE;
            else if (none_take) op = OP_SKIP;
        end
    end

    // Mask, address and overflow state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            pc_q   <= RESET_PC;
            ovf_q  <= 1'b0;
        end else begin
            unique case (op)
                OP_TAKE:  pc_q <= br_target;
                OP_SKIP:  pc_q <= br_fall;
                OP_SPLIT: begin
                    mask_q <= take_mask;
                    pc_q   <= br_target;
                end
                OP_SPILL: ovf_q <= 1'b1;
                OP_FLIP: begin
                    mask_q <= top_alt;
                    pc_q   <= top_alt_pc;
                end
                OP_POP: begin
                    mask_q <= top_restore;
                    pc_q   <= top_join_pc;
                end
                default: ;
            endcase
        end
    end

    assign act_mask = mask_q;
    assign next_pc  = pc_q;
    assign ovf      = ovf_q;

endmodule

// File: rtl/simt_div_chk.sv
// Module: simt_div_chk
// Property checker for simt_divergence_ctl, attached by bind below.
// Assumes: observes top ports plus the stack occupancy.
module simt_div_chk #(
    parameter int LANES = 8,
    parameter int DEPTH = 8,
    parameter int PCW   = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             br_valid,
    input logic [LANES-1:0] br_pred,
    input logic [PCW-1:0]   br_target,
    input logic [PCW-1:0]   br_fall,
    input logic             merge_valid,
    input logic [LANES-1:0] act_mask,
    input logic [PCW-1:0]   next_pc,
    input logic             ovf,
    input logic [CW-1:0]    depth
);

    logic [LANES-1:0] tk;
    logic             br_only, uni_t, uni_n, divg;

    // Reference branch classification from ports.
    always_comb begin
        tk      = act_mask & br_pred;
        br_only = br_valid && !merge_valid;
        uni_t   = (tk == act_mask);
        uni_n   = (tk == '0) && (act_mask != '0);
        divg    = !uni_t && !uni_n;
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (act_mask == '1 && !ovf && depth == '0));

    a_r2_uniform_take: assert property (@(posedge clk) disable iff (!rst_n)
        (br_only && uni_t) |=> (next_pc == $past(br_target) && $stable(act_mask) && $stable(depth)));

    a_r3_uniform_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (br_only && uni_n) |=> (next_pc == $past(br_fall) && $stable(act_mask) && $stable(depth)));

    a_r4_split_push: assert property (@(posedge clk) disable iff (!rst_n)
        (br_only && divg && depth != CW'(DEPTH)) |=>
        (depth == $past(depth) + CW'(1) && act_mask == $past(tk) && next_pc == $past(br_target)));

    a_r8_empty_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (merge_valid && depth == '0) |=> ($stable(act_mask) && $stable(next_pc) && $stable(depth)));

    a_r9_spill: assert property (@(posedge clk) disable iff (!rst_n)
        (br_only && divg && depth == CW'(DEPTH)) |=> (ovf && $stable(act_mask) && $stable(next_pc) && $stable(depth)));

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CW'(DEPTH));

    a_r10_marker_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (merge_valid && depth != '0) |=> (depth <= $past(depth)));

endmodule

bind simt_divergence_ctl simt_div_chk #(.LANES(LANES), .DEPTH(DEPTH), .PCW(PCW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_valid    (br_valid),
    .br_pred     (br_pred),
    .br_target   (br_target),
    .br_fall     (br_fall),
    .merge_valid (merge_valid),
    .act_mask    (act_mask),
    .next_pc     (next_pc),
    .ovf         (ovf),
    .depth       (depth)
);

// File: tb/test_simt_divergence_ctl.sv
// Directed bench: one task per scenario, each checking its own results.
module test_simt_divergence_ctl;

    localparam int LANES = 8;
    localparam int DEPTH = 4;
    localparam int PCW   = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             br_valid = 1'b0;
    logic [LANES-1:0] br_pred = '0;
    logic [PCW-1:0]   br_target = '0;
    logic [PCW-1:0]   br_fall = '0;
    logic [PCW-1:0]   br_join_pc = '0;
    logic             merge_valid = 1'b0;
    logic [LANES-1:0] act_mask;
    logic [PCW-1:0]   next_pc;
    logic             ovf;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    simt_divergence_ctl #(.LANES(LANES), .DEPTH(DEPTH), .PCW(PCW)) i_simt_divergence_ctl (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pred(br_pred),
        .br_target(br_target), .br_fall(br_fall), .br_join_pc(br_join_pc),
        .merge_valid(merge_valid), .act_mask(act_mask), .next_pc(next_pc), .ovf(ovf)
    );

    task automatic chk(input string req, input logic [LANES-1:0] em, input logic [PCW-1:0] ep);
        n_vec++;
        if (act_mask !== em || next_pc !== ep) begin
            n_fail++;
            $display("FAIL %s: mask=%h pc=%h expected mask=%h pc=%h", req, act_mask, next_pc, em, ep);
        end
    endtask

    task automatic chk_ovf(input string req, input logic eo);
        n_vec++;
        if (ovf !== eo) begin
            n_fail++;
            $display("FAIL %s: ovf=%b expected %b", req, ovf, eo);
        end
    endtask

    // Drive one event for one clock; return at the following falling edge.
    task automatic ev(input logic b, input logic m, input logic [LANES-1:0] p,
                      input logic [PCW-1:0] t, input logic [PCW-1:0] f, input logic [PCW-1:0] j);
        @(negedge clk);
        br_valid = b; merge_valid = m; br_pred = p;
        br_target = t; br_fall = f; br_join_pc = j;
        @(negedge clk);
        br_valid = 1'b0; merge_valid = 1'b0; br_pred = '0;
    endtask

    task automatic branch(input logic [LANES-1:0] p, input logic [PCW-1:0] t,
                          input logic [PCW-1:0] f, input logic [PCW-1:0] j);
        ev(1'b1, 1'b0, p, t, f, j);
    endtask

    task automatic marker();
        ev(1'b0, 1'b1, '0, '0, '0, '0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset mask/pc", 8'hFF, 16'h0000);
        chk_ovf("R1 reset ovf", 1'b0);
    endtask

    task automatic t_uniform();
        branch(8'hFF, 16'h0100, 16'h0011, 16'h0200);
        chk("R2 uniform taken", 8'hFF, 16'h0100);
        branch(8'h00, 16'h0101, 16'h0011, 16'h0200);
        chk("R3 uniform not taken", 8'hFF, 16'h0011);
        marker();
        chk("R8 marker on empty stack", 8'hFF, 16'h0011);
    endtask

    task automatic t_diverge();
        branch(8'h0F, 16'h0120, 16'h0110, 16'h0140);
        chk("R4 divergent taken path", 8'h0F, 16'h0120);
        marker();
        chk("R5 switch to waiting path", 8'hF0, 16'h0110);
        marker();
        chk("R6 rejoin restores mask", 8'hFF, 16'h0140);
        marker();
        chk("R8 extra marker after pop", 8'hFF, 16'h0140);
    endtask

    task automatic t_nested();
        branch(8'h3C, 16'h0200, 16'h0210, 16'h0300);
        chk("R7 outer taken", 8'h3C, 16'h0200);
        branch(8'h0C, 16'h0220, 16'h0230, 16'h0240);
        chk("R7 inner taken", 8'h0C, 16'h0220);
        marker();
        chk("R7 inner waiting path", 8'h30, 16'h0230);
        marker();
        chk("R7 inner rejoin", 8'h3C, 16'h0240);
        marker();
        chk("R7 outer waiting path", 8'hC3, 16'h0210);
        marker();
        chk("R7 outer rejoin", 8'hFF, 16'h0300);
    endtask

    task automatic t_inactive();
        branch(8'h0F, 16'h0400, 16'h0410, 16'h0420);
        chk("R4 split for R11", 8'h0F, 16'h0400);
        branch(8'hAF, 16'h0430, 16'h0431, 16'h0432);
        chk("R11 disabled lanes ignored, taken", 8'h0F, 16'h0430);
        branch(8'hF0, 16'h0440, 16'h0441, 16'h0442);
        chk("R11 disabled lanes ignored, not taken", 8'h0F, 16'h0441);
        marker();
        chk("R11 no push by uniform, waiting path", 8'hF0, 16'h0410);
        marker();
        chk("R11 no push by uniform, rejoin", 8'hFF, 16'h0420);
    endtask

    task automatic t_same_cycle();
        branch(8'h01, 16'h0500, 16'h0510, 16'h0520);
        chk("R4 single-lane split", 8'h01, 16'h0500);
        ev(1'b1, 1'b1, 8'h00, 16'h05EE, 16'h05FF, 16'h05DD);
        chk("R10 marker wins over branch", 8'hFE, 16'h0510);
        marker();
        chk("R10 one level unwound", 8'hFF, 16'h0520);
        ev(1'b1, 1'b1, 8'h0F, 16'h05AA, 16'h05BB, 16'h05CC);
        chk("R10 both on empty stack", 8'hFF, 16'h0520);
    endtask

    task automatic t_overflow();
        branch(8'hFE, 16'h0701, 16'h0711, 16'h0721);
        branch(8'hFC, 16'h0702, 16'h0712, 16'h0722);
        branch(8'hF8, 16'h0703, 16'h0713, 16'h0723);
        branch(8'hF0, 16'h0704, 16'h0714, 16'h0724);
        chk("R4 fourth level", 8'hF0, 16'h0704);
        chk_ovf("R9 full but no overflow yet", 1'b0);
        branch(8'hE0, 16'h07AA, 16'h07BB, 16'h07CC);
        chk("R9 refused branch no effect", 8'hF0, 16'h0704);
        chk_ovf("R9 overflow raised", 1'b1);
        marker(); chk("R9 unwind 4 alt", 8'h08, 16'h0714);
        marker(); chk("R9 unwind 4 join", 8'hF8, 16'h0724);
        marker(); chk("R9 unwind 3 alt", 8'h04, 16'h0713);
        marker(); chk("R9 unwind 3 join", 8'hFC, 16'h0723);
        marker(); chk("R9 unwind 2 alt", 8'h02, 16'h0712);
        marker(); chk("R9 unwind 2 join", 8'hFE, 16'h0722);
        marker(); chk("R9 unwind 1 alt", 8'h01, 16'h0711);
        marker(); chk("R9 unwind 1 join", 8'hFF, 16'h0721);
        marker(); chk("R9 nothing pushed by refused branch", 8'hFF, 16'h0721);
        chk_ovf("R9 overflow sticky", 1'b1);
    endtask

    task automatic t_rereset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 second reset", 8'hFF, 16'h0000);
        chk_ovf("R1 second reset clears ovf", 1'b0);
    endtask

    initial begin
        t_reset();
        t_uniform();
        t_diverge();
        t_nested();
        t_inactive();
        t_same_cycle();
        t_overflow();
        t_rereset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule